// File: doc/BRIEF.md
# Modem Handshake Status Register

This block watches the four active-low handshake lines a modem presents to a serial port: clear-to-send, data-set-ready, ring-indicator and data-carrier-detect. It brings each line into the local clock domain and shows the current line levels, inverted so that an asserted line reads as 1, in the upper half of an 8-bit status byte. The lower half holds one sticky change flag per line. A flag records that its line moved since the status byte was last read.

A CPU reads the byte by raising a one-cycle read strobe. The byte is valid on the data output during the strobe cycle, and the clock edge that ends the strobe clears the change flags. A change that is detected on that same edge stays recorded for the next read. The ring flag records only the moment the ring line returns high. The other three flags record movement in either direction. An interrupt request is raised while the interrupt enable is high and any change flag is set. The lines have no path into any transmit or receive datapath.

Top module: `mdm_status_reg`

## Requirements
- R1: After reset the status byte reads 0x00 and the interrupt request is low, with all four inputs held high.
- R2: Status bits 4, 5, 6 and 7 read as the inverse of clear-to-send, data-set-ready, ring-indicator and data-carrier-detect respectively.
- R3: Bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (data-carrier-detect) set when their line changes level in either direction, and stay set until a read.
- R4: Bit 2 sets only when the ring-indicator input goes from low to high. A high-to-low move of that input leaves bit 2 at 0.
- R5: While the read strobe is high the output shows the flags as they are before the clear, and the clock edge that ends the strobe clears all four flags.
- R6: A change that is detected on the same edge as a read leaves its flag set after that read.
- R7: The interrupt request is high exactly when the enable input is high and at least one change flag is set. It stays high until a read clears the flags.
- R8: A level change on an input reaches the upper nibble two clock edges after it is set up, and reaches its change flag on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_ni | input | 1 | Data-set-ready line, active low, asynchronous |
| dcd_ni | input | 1 | Carrier-detect line, active low, asynchronous |
| ri_ni | input | 1 | Ring-indicator line, active low, asynchronous |
| rd_stb_i | input | 1 | One-cycle read strobe; clears the change flags on its edge |
| irq_en_i | input | 1 | Enable for the modem status interrupt |
| rdata_o | output | 8 | Status byte: line levels in [7:4], change flags in [3:0] |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
The main sweep drives every ordered pair of the sixteen input patterns. For each pair, the bench first applies one pattern and clears the flags, then applies the other. This separates any-direction detection on three lines from the rising-only ring flag, and it catches swapped bit positions, because every combination of simultaneous changes appears. The sweep alternates the interrupt enable, so that the gating and the sticky behaviour of the request are both seen. Further directed sequences step a change through the synchronizer one edge at a time to pin the latency. They also land a change exactly on a read edge, to show that a flag already set is cleared while the newly detected one is kept.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // line order shared by the delta nibble and the level nibble
   localparam int unsigned LINES   = 4;
   localparam int unsigned L_CTS   = 0;
   localparam int unsigned L_DSR   = 1;
   localparam int unsigned L_RI    = 2;
   localparam int unsigned L_DCD   = 3;
   // 1: flag any transition, 0: flag only a low-to-high input move
   localparam logic [LINES-1:0] ANY_EDGE_MASK = 4'b1011;
   localparam int unsigned BYTE_W  = 2 * LINES;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q[s] <= {W{IDLE}};
         end else if (s == 0) begin
            chain_q[s] <= d_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge #(
   parameter int unsigned   W        = 4,
   parameter logic [W-1:0]  ANY_MASK = '1,
   parameter logic          IDLE     = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] evt_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= {W{IDLE}};
      else         prev_q <= lvl_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      if (ANY_MASK[i]) begin : g_any
         assign evt_o[i] = lvl_i[i] ^ prev_q[i];
      end else begin : g_rise
         assign evt_o[i] = lvl_i[i] & ~prev_q[i];
      end
   end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int unsigned W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] evt_i,
   input  logic         clr_i,
   output logic [W-1:0] flag_o
);
   logic [W-1:0] flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= '0;
      else         flag_q <= (flag_q & ~{W{clr_i}}) | evt_i;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
   import mdm_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cts_ni,
   input  logic              dsr_ni,
   input  logic              dcd_ni,
   input  logic              ri_ni,
   input  logic              rd_stb_i,
   input  logic              irq_en_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic              irq_o
);
   logic [LINES-1:0] raw_w;
   logic [LINES-1:0] lvl_w;
   logic [LINES-1:0] evt_w;
   logic [LINES-1:0] flag_w;

   always_comb begin
      raw_w        = '1;
      raw_w[L_CTS] = cts_ni;
      raw_w[L_DSR] = dsr_ni;
      raw_w[L_RI]  = ri_ni;
      raw_w[L_DCD] = dcd_ni;
   end

   mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES), .IDLE(1'b1)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w),
      .q_o   (lvl_w)
   );

   mdm_edge #(.W(LINES), .ANY_MASK(ANY_EDGE_MASK), .IDLE(1'b1)) edge_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl_w),
      .evt_o (evt_w)
   );

   mdm_delta #(.W(LINES)) delta_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt_w),
      .clr_i (rd_stb_i),
      .flag_o(flag_w)
   );

   assign rdata_o = {~lvl_w, flag_w};
   assign irq_o   = irq_en_i & (|flag_w);
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       rd_stb_i,
   input logic       irq_en_i,
   input logic       irq_o,
   input logic [7:0] rdata_o,
   input logic [3:0] evt_w
);
   // R3
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_stb_i) |=> ((rdata_o[3:0] & $past(rdata_o[3:0])) == $past(rdata_o[3:0])));

   // R5
   clear_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_stb_i |=> (rdata_o[3:0] == $past(evt_w)));

   // R6
   evt_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|evt_w) |=> ((rdata_o[3:0] & $past(evt_w)) == $past(evt_w)));

   // R4
   ri_rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_w[2] |-> (rdata_o[6] == 1'b0));

   // R7
   irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !rd_stb_i && irq_en_i) |=> (irq_o || !irq_en_i));
endmodule

bind mdm_status_reg mdm_status_chk chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .rd_stb_i(rd_stb_i),
   .irq_en_i(irq_en_i),
   .irq_o   (irq_o),
   .rdata_o (rdata_o),
   .evt_w   (evt_w)
);

// File: tb/mdm_status_reg_tb.sv
module mdm_status_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pat = 4'hF;   // [0]=cts [1]=dsr [2]=ri [3]=dcd
   logic       rd = 1'b0;
   logic       en = 1'b0;
   logic [7:0] rdata;
   logic       irq;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   mdm_status_reg dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .cts_ni  (pat[0]),
      .dsr_ni  (pat[1]),
      .dcd_ni  (pat[3]),
      .ri_ni   (pat[2]),
      .rd_stb_i(rd),
      .irq_en_i(en),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_delta(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] d;
      d    = a ^ b;
      d[2] = ~a[2] & b[2];
      return d;
   endfunction

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read(output logic [7:0] v);
      rd = 1'b1;
      #1 v = rdata;
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [3:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {irq, rdata}, 9'h000);
      rst_n = 1'b1;
      settle();
      check("R1", {irq, rdata}, 9'h000);

      // R2 R3 R4 R7 exhaustive pattern pair sweep
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            en  = b[0] ^ a[0];
            pat = 4'(a);
            settle();
            do_read(v);
            check("R5", {1'b0, rdata[3:0] == 4'h0, 4'h0, 3'h0}, 9'h080);
            pat = 4'(b);
            settle();
            d = exp_delta(4'(a), 4'(b));
            check("R2", {5'h0, rdata[7:4]}, {5'h0, ~4'(b)});
            check("R3", {5'h0, rdata[3] , rdata[1:0], 1'b0}, {5'h0, d[3], d[1:0], 1'b0});
            check("R4", {8'h0, rdata[2]}, {8'h0, d[2]});
            check("R7", {8'h0, irq}, {8'h0, en & (|d)});
            repeat (3) @(negedge clk);
            check("R7", {8'h0, irq}, {8'h0, en & (|d)});
            do_read(v);
            check("R5", {5'h0, v[3:0]}, {5'h0, d});
            check("R5", {5'h0, rdata[3:0]}, 9'h000);
            check("R7", {8'h0, irq}, 9'h000);
         end
      end

      // R8 latency, one edge at a time
      en  = 1'b1;
      pat = 4'hF;
      settle();
      do_read(v);
      pat[1] = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R8", {1'b0, rdata}, 9'h000);
      @(posedge clk); @(negedge clk);
      check("R8", {1'b0, rdata}, 9'h020);
      @(posedge clk); @(negedge clk);
      check("R8", {irq, rdata}, 9'h122);

      // R6 change landing on the read edge
      pat[0] = 1'b0;
      settle();                       // flags now 0x3
      pat[0] = 1'b1;                  // new cts change
      @(posedge clk); @(posedge clk); @(negedge clk);
      do_read(v);                     // read edge coincides with detection
      check("R6", {1'b0, v}, 9'h023);
      check("R6", {1'b0, rdata}, 9'h021);
      do_read(v);
      check("R6", {1'b0, v}, 9'h021);
      check("R5", {irq, rdata}, 9'h020);

      // R4 ring falling alone leaves flag clear, rise sets it
      pat = 4'hF;
      settle();
      do_read(v);
      pat[2] = 1'b0;
      settle();
      check("R4", {irq, rdata}, 9'h040);
      pat[2] = 1'b1;
      settle();
      check("R4", {irq, rdata}, 9'h104);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule